// File: doc/BRIEF.md
# Two-Stage 32-to-1 Word Serializer with Loopback Steering

This block turns a 32-bit parallel word into a single serial bit stream clocked by one fast bit clock. It counts bit clocks modulo 32 to produce a word-rate clock, which upstream logic uses to launch each new word. Once per word period, a load strobe copies the word into four 8-bit lane shift registers. Each lane shifts at one quarter of the bit rate.

A tree of 2:1 selectors merges the four lane outputs into one stream. One level builds two half-rate streams, and a final registered selector builds the full-rate stream. Two select inputs shift the load strobe in steps of eight bit clocks, so the capture point can be placed where the parallel data is settled.

An active-low mode input steers the stream onto either the normal output or the loopback output. The output that is not selected stays at 0.

Top module: `ser32_two_stage`

## Requirements
- R1: After reset release, `word_clk` is high for 16 bit clocks and then low for 16, with a period of exactly 32 bit clocks. Counting the first bit-clock edge after reset release as edge 0, `word_clk` is high after edges 0..14 and low after edges 15..30, and this pattern repeats.
- R2: The word is captured on the bit-clock edge whose index modulo 32 equals 8 × `phase_sel` (`phase_sel` is unsigned 0..3). With `phase_sel` = 0, this is the first edge after the word clock rises.
- R3: The first serial bit of a captured word appears after the 3rd bit-clock edge following the capture edge. The bits then come out one per bit clock, `din[31]` first and `din[0]` last.
- R4: Successive words follow each other with no idle bit. Bit `din[0]` of one word is followed directly by bit `din[31]` of the next captured word.
- R5: `din` is sampled only on the capture edge. A change of `din` at any other time has no effect on the word being serialized.
- R6: While `loop_n` is 1, the stream appears on `dout` and `dloop` stays 0. While `loop_n` is 0, the stream appears on `dloop` and `dout` stays 0. A change of `loop_n` takes effect in the same cycle.
- R7: Reset is synchronous and active high. During reset and after it, both data outputs read 0 until the first captured bit emerges, and `word_clk` reads 1 while reset is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 32 | Parallel word; bit 31 is sent first |
| phase_sel | input | 2 | Capture phase, in steps of 8 bit clocks |
| loop_n | input | 1 | 0 steers the stream to the loopback output |
| word_clk | output | 1 | Bit clock divided by 32 |
| dout | output | 1 | Normal serial output |
| dloop | output | 1 | Loopback serial output |

## Verification
The assertions check several rules on every cycle: the divider steps by one, `word_clk` rises only at count 0, the lane registers change only on quarter-rate edges, the unselected output stays at 0, and the state right after reset is clean. The bit order, the three-cycle latency from capture to the first bit, the placement of the capture edge for each phase value, and the back-to-back joining of words can only be shown by the bench. It does this by comparing whole serialized words against the driven input for each phase and mode.

// File: rtl/ser32_two_stage.sv
module ser32_two_stage #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*LANE_W-1:0]   din,
  input  logic [1:0]                phase_sel,
  input  logic                      loop_n,
  output logic                      word_clk,
  output logic                      dout,
  output logic                      dloop
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = $clog2(WORD_W);

  logic [CNT_W-1:0]             cnt;
  logic [LANES-1:0][LANE_W-1:0] sr;
  logic [LANES-1:0]             lat;
  logic                         hr0, hr1, ser_q;
  logic                         load;

  assign load     = (cnt == {phase_sel, 3'b000});
  assign word_clk = ~cnt[CNT_W-1];

  always_ff @(posedge clk)
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else if (load) begin
      for (int k = 0; k < LANES; k++)
        for (int j = 0; j < LANE_W; j++)
          sr[k][LANE_W-1-j] <= din[WORD_W-1-k-LANES*j];
    end else if (cnt[1:0] == 2'd0) begin
      for (int k = 0; k < LANES; k++)
        sr[k] <= {sr[k][LANE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk)
    if (rst) lat <= '0;
    else if (cnt[1:0] == 2'd1)
      for (int k = 0; k < LANES; k++) lat[k] <= sr[k][LANE_W-1];

  always_ff @(posedge clk)
    if (rst) begin
      hr0 <= 1'b0;
      hr1 <= 1'b0;
    end else if (!cnt[0]) begin
      hr0 <= cnt[1] ? lat[0] : lat[2];
      hr1 <= cnt[1] ? lat[1] : lat[3];
    end

  always_ff @(posedge clk)
    if (rst) ser_q <= 1'b0;
    else     ser_q <= cnt[0] ? hr0 : hr1;

  assign dout  =  loop_n & ser_q;
  assign dloop = ~loop_n & ser_q;
endmodule

// File: rtl/ser32_checker.sv
module ser32_checker (
  input logic        clk,
  input logic        rst,
  input logic        loop_n,
  input logic        dout,
  input logic        dloop,
  input logic        word_clk,
  input logic [4:0]  cnt,
  input logic [31:0] lanes,
  input logic        ser
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    !$fell(rst) |-> cnt == 5'($past(cnt) + 5'd1));

  a_r1_wclk_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(word_clk) |-> cnt == 5'd0);

  a_r5_lanes_hold: assert property (@(posedge clk) disable iff (rst)
    (!$fell(rst) && $past(cnt[1:0]) != 2'd0) |-> $stable(lanes));

  a_r6_normal_quiet: assert property (@(posedge clk) disable iff (rst)
    !loop_n |-> !dout);

  a_r6_loop_quiet: assert property (@(posedge clk) disable iff (rst)
    loop_n |-> !dloop);

  a_r7_clean_start: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!ser && word_clk && cnt == 5'd0 && lanes == 32'd0));
endmodule

bind ser32_two_stage ser32_checker u_chk (
  .clk(clk), .rst(rst), .loop_n(loop_n), .dout(dout), .dloop(dloop),
  .word_clk(word_clk), .cnt(cnt), .lanes(sr), .ser(ser_q)
);

// File: tb/test_ser32_two_stage.sv
module test_ser32_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam logic [34:0] VEC [NVEC] = '{
    {32'h8000_0001, 2'd0, 1'b1},
    {32'hA5A5_3C3C, 2'd1, 1'b1},
    {32'hFFFF_FFFF, 2'd2, 1'b0},
    {32'h0000_0000, 2'd3, 1'b1},
    {32'h1234_5678, 2'd3, 1'b0},
    {32'hDEAD_BEEF, 2'd0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] din = '0;
  logic [1:0] phase_sel = '0;
  logic loop_n = 1'b1;
  logic word_clk, dout, dloop;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser32_two_stage i_ser32_two_stage (
    .clk(clk), .rst(rst), .din(din), .phase_sel(phase_sel),
    .loop_n(loop_n), .word_clk(word_clk), .dout(dout), .dloop(dloop)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 dout in reset", dout, 1'b0);
    chk("R7 dloop in reset", dloop, 1'b0);
    chk("R7 word_clk in reset", word_clk, 1'b1);
  endtask

  task automatic run_vec(input logic [31:0] a, input logic [1:0] s, input logic lp);
    logic [31:0] b;
    int base, i;
    logic e;
    b = {a[0], a[31:1]} ^ 32'h0F0F_0F0F;
    do_reset();
    din = a; phase_sel = s; loop_n = lp;
    rst = 1'b0;
    base = 8 * int'(s);
    for (int n = 0; n < base + 67; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == base) din = ~a;   // R5: change after capture edge
      chk("R1 word_clk", word_clk, ((n + 1) % 32) < 16);
      if (n < base + 3) e = 1'b0;
      else begin
        i = n - base - 3;
        e = (i < 32) ? a[31 - i] : b[31 - (i - 32)];
      end
      if (n == base + 32) din = b;
      if (n == base + 30) din = b;  // settled before second capture (R2, R4)
      if (lp) begin
        chk("R3 R4 R5 dout stream", dout, e);
        chk("R6 dloop idle", dloop, 1'b0);
      end else begin
        chk("R3 R4 R5 dloop stream", dloop, e);
        chk("R6 dout idle", dout, 1'b0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][34:3], VEC[v][2:1], VEC[v][0]);

    // R6: switching mode mid-stream moves the stream at once
    do_reset();
    din = 32'hFFFF_FFFF; phase_sel = 2'd0; loop_n = 1'b1; rst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R6 dout before switch", dout, 1'b1);
    loop_n = 1'b0; #1;
    chk("R6 dloop after switch", dloop, 1'b1);
    chk("R6 dout after switch", dout, 1'b0);

    // R7: reset mid-stream clears outputs and restarts word clock
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 dloop after mid reset", dloop, 1'b0);
    chk("R7 word_clk after mid reset", word_clk, 1'b1);
    rst = 1'b0; loop_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 dout before first bit", dout, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule